// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block sits beside a UART receiver and reports when the incoming serial stream has gone quiet. It counts ticks of the 16x oversampling clock after each received character, converts them into bit times and then into whole character times using the programmed frame format, and raises a sticky pending flag once the line has stayed idle for longer than a set number of character times. Interrupt logic uses the flag to learn that a sender has finished a burst, even when the receive FIFO has not reached its threshold.

A character time is the full length of one frame: a start bit, the data bits, an optional parity bit and one or two stop bits, so it changes with the line settings. Detection is armed only by a received character, is held off while the receiver is paused by hardware flow control, and the flag is cleared only by dropping the enable input. Raising the enable again re-arms detection for the next burst.

Top module: `rx_idle_timeout`

## Requirements
- R1: After a synchronous reset, `idle_pending` is 0.
- R2: One bit time is 16 `os_tick` pulses; one character time is 1 start bit plus 5 + `word_len` data bits (`word_len` 0..3 gives 5..8), plus 1 if `parity_en` is 1, plus 2 stop bits if `stop_two` is 1 else 1, for 7 to 12 bit times.
- R3: With the detector armed and enabled, `idle_pending` stays 0 through the first LIMIT_CHARS character times of ticks after the last character strobe and becomes 1 after the edge of the next tick; the idle count saturates at the limit.
- R4: A `rx_char` strobe restarts the idle count from zero.
- R5: While no character has arrived since reset or since the enable was last low, ticks never set `idle_pending`.
- R6: While `flow_stall` is 1, `idle_pending` does not become 1, and the idle count is cleared, so a full new window is needed after the stall ends.
- R7: Once set, `idle_pending` stays 1 while `idle_en` is 1, regardless of ticks, strobes or stalls.
- R8: With `idle_en` at 0 for one cycle, `idle_pending` is 0 after that edge and detection is disarmed; after re-enabling, a new character is needed before an event can occur.
- R9: Clock cycles without `os_tick` do not advance the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | One-cycle pulse per 16x oversampling period |
| word_len | input | 2 | Data bits per frame minus 5 |
| parity_en | input | 1 | Frame carries a parity bit |
| stop_two | input | 1 | Frame carries two stop bits |
| rx_char | input | 1 | One-cycle strobe for each received character |
| flow_stall | input | 1 | Receiver held off by hardware handshake |
| idle_en | input | 1 | Idle event enable; low clears and disarms |
| idle_pending | output | 1 | Sticky idle timeout flag |

## Verification
The assertions assume that `rx_char` and `os_tick` are single-cycle pulses and that the frame format does not change while an idle window is being timed. The stimulus drives every pulse for exactly one clock, never puts a tick and a strobe in the same cycle, and alters the frame fields only after the flag has been cleared and before the next strobe. Expected firing points are computed from the frame length formula and the limit, counted in ticks rather than cycles.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

    localparam int TICKS_PER_BIT  = 16;
    localparam int MAX_FRAME_BITS = 12;
    localparam int FRAME_W        = $clog2(MAX_FRAME_BITS + 1);

    typedef enum logic [1:0] {
        DATA5 = 2'd0,
        DATA6 = 2'd1,
        DATA7 = 2'd2,
        DATA8 = 2'd3
    } data_len_e;

    typedef struct packed {
        data_len_e data_len;
        logic      parity_on;
        logic      two_stops;
    } frame_fmt_t;

    function automatic logic [FRAME_W-1:0] frame_bits(input frame_fmt_t f);
        logic [FRAME_W-1:0] n;
        n = FRAME_W'(6) + FRAME_W'(f.data_len);
        n = n + FRAME_W'(f.parity_on);
        n = n + (f.two_stops ? FRAME_W'(2) : FRAME_W'(1));
        return n;
    endfunction

endpackage

// File: rtl/rx_idle_frame_len.sv
module rx_idle_frame_len
    import rx_idle_pkg::*;
(
    input  frame_fmt_t         fmt,
    output logic [FRAME_W-1:0] bits_per_char
);

    always_comb begin
        bits_per_char = frame_bits(fmt);
        // R2: frame length stays within 7..12 bit times
        a_frame_range_r2: assert (bits_per_char >= FRAME_W'(7) && bits_per_char <= FRAME_W'(12))
            else $error("frame length out of range");
    end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_idle_pkg::*;
#(
    parameter int LIMIT_CHARS   = 4,
    parameter int TICKS_PER_BIT_P = TICKS_PER_BIT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cnt_en,
    input  logic [FRAME_W-1:0] bits_per_char,
    output logic               at_limit
);

    localparam int SUB_W = (TICKS_PER_BIT_P > 1) ? $clog2(TICKS_PER_BIT_P) : 1;
    localparam int CHR_W = $clog2(LIMIT_CHARS + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT_P - 1);
    localparam logic [CHR_W-1:0] CHR_LIM  = CHR_W'(LIMIT_CHARS);

    logic [SUB_W-1:0]   sub_q;
    logic [FRAME_W-1:0] bit_q;
    logic [CHR_W-1:0]   chr_q;
    logic               bit_done;
    logic               chr_done;

    assign at_limit = (chr_q == CHR_LIM);
    assign bit_done = (sub_q == SUB_LAST);
    assign chr_done = bit_done && (bit_q == bits_per_char - FRAME_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sub_q <= '0;
            bit_q <= '0;
            chr_q <= '0;
        end else if (cnt_en && !at_limit) begin
            sub_q <= bit_done ? '0 : sub_q + SUB_W'(1);
            if (bit_done) begin
                bit_q <= chr_done ? '0 : bit_q + FRAME_W'(1);
            end
            if (chr_done) begin
                chr_q <= chr_q + CHR_W'(1);
            end
        end
    end

    // R3: the character count never passes the limit
    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        chr_q <= CHR_LIM);

    // R4: a restart leaves the count below the limit on the next cycle
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> !at_limit);

    // R9: without a count enable the position is held
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr) |=> $stable(chr_q) && $stable(sub_q));

endmodule

// File: rtl/rx_idle_flag.sv
module rx_idle_flag (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic char_seen,
    input  logic stall,
    input  logic tick,
    input  logic at_limit,
    output logic armed,
    output logic pending
);

    logic fire;

    assign fire = enable && armed && !stall && !char_seen && tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            pending <= 1'b0;
        end else if (!enable) begin
            armed   <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (char_seen) begin
                armed <= 1'b1;
            end
            if (fire) begin
                pending <= 1'b1;
            end
        end
    end

    // R8: a low enable clears the flag and disarms
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pending && !armed));

    // R7: the flag is sticky while enabled
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && enable) |=> pending);

    // R6: no event while the receiver is stalled
    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (!pending && stall) |=> !pending);

    // R5: no event before a character has armed detection
    p_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
        (!armed && !pending) |=> !pending);

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rx_idle_pkg::*;
#(
    parameter int LIMIT_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic       stop_two,
    input  logic       rx_char,
    input  logic       flow_stall,
    input  logic       idle_en,
    output logic       idle_pending
);

    frame_fmt_t         fmt;
    logic [FRAME_W-1:0] bits_per_char;
    logic               armed;
    logic               at_limit;
    logic               cnt_clr;
    logic               cnt_en;

    assign fmt.data_len  = data_len_e'(word_len);
    assign fmt.parity_on = parity_en;
    assign fmt.two_stops = stop_two;

    assign cnt_clr = rx_char || flow_stall || !armed;
    assign cnt_en  = os_tick && armed && idle_en;

    rx_idle_frame_len u_len (
        .fmt           (fmt),
        .bits_per_char (bits_per_char)
    );

    rx_idle_timer #(
        .LIMIT_CHARS     (LIMIT_CHARS),
        .TICKS_PER_BIT_P (TICKS_PER_BIT)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .clr           (cnt_clr),
        .cnt_en        (cnt_en),
        .bits_per_char (bits_per_char),
        .at_limit      (at_limit)
    );

    rx_idle_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .enable    (idle_en),
        .char_seen (rx_char),
        .stall     (flow_stall),
        .tick      (os_tick),
        .at_limit  (at_limit),
        .armed     (armed),
        .pending   (idle_pending)
    );

    // R1: flag low right after reset
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !idle_pending);

endmodule

// File: tb/rx_idle_timeout_test.sv
module rx_idle_timeout_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic       stop_two = 1'b0;
    logic       rx_char = 1'b0;
    logic       flow_stall = 1'b0;
    logic       idle_en = 1'b0;
    logic       idle_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_idle_timeout uut (
        .clk          (clk),
        .rst          (rst),
        .os_tick      (os_tick),
        .word_len     (word_len),
        .parity_en    (parity_en),
        .stop_two     (stop_two),
        .rx_char      (rx_char),
        .flow_stall   (flow_stall),
        .idle_en      (idle_en),
        .idle_pending (idle_pending)
    );

    function automatic int window(input int wl, input bit p, input bit s);
        return 4 * 16 * (1 + 5 + wl + int'(p) + (s ? 2 : 1));
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: idle_pending=%b expected %b", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        rx_char = 1'b1;
        @(negedge clk);
        rx_char = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
            cycles(gap);
        end
    endtask

    task automatic set_fmt(input int wl, input bit p, input bit s);
        word_len = 2'(wl); parity_en = p; stop_two = s;
    endtask

    task automatic disable_once();
        idle_en = 1'b0;
        @(negedge clk);
        idle_en = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 reset", idle_pending, 1'b0);
    endtask

    task automatic t_window(input int wl, input bit p, input bit s, input int gap);
        int w;
        w = window(wl, p, s);
        disable_once();
        set_fmt(wl, p, s);
        strobe();
        ticks(w, gap);
        check("R2/R3 before limit", idle_pending, 1'b0);
        ticks(1, gap);
        check("R2/R3 past limit", idle_pending, 1'b1);
    endtask

    task automatic t_restart();
        int w;
        w = window(3, 0, 0);
        disable_once();
        set_fmt(3, 0, 0);
        strobe();
        ticks(w - 5, 0);
        strobe();
        ticks(w, 0);
        check("R4 restart holds off", idle_pending, 1'b0);
        ticks(1, 0);
        check("R4 fires after new window", idle_pending, 1'b1);
    endtask

    task automatic t_unarmed();
        disable_once();
        set_fmt(0, 0, 0);
        ticks(window(0, 0, 0) + 50, 0);
        check("R5 no char no event", idle_pending, 1'b0);
    endtask

    task automatic t_stall();
        int w;
        w = window(1, 1, 0);
        disable_once();
        set_fmt(1, 1, 0);
        strobe();
        ticks(w - 2, 0);
        flow_stall = 1'b1;
        ticks(300, 0);
        check("R6 no event during stall", idle_pending, 1'b0);
        flow_stall = 1'b0;
        ticks(w, 0);
        check("R6 full window after stall", idle_pending, 1'b0);
        ticks(1, 0);
        check("R6 fires after stall ends", idle_pending, 1'b1);
    endtask

    task automatic t_sticky();
        strobe();
        ticks(20, 0);
        flow_stall = 1'b1;
        cycles(3);
        flow_stall = 1'b0;
        check("R7 sticky", idle_pending, 1'b1);
    endtask

    task automatic t_clear_rearm();
        int w;
        w = window(3, 0, 0);
        idle_en = 1'b0;
        @(negedge clk);
        check("R8 cleared by enable low", idle_pending, 1'b0);
        idle_en = 1'b1;
        set_fmt(3, 0, 0);
        ticks(w + 20, 0);
        check("R8 disarmed after re-enable", idle_pending, 1'b0);
        strobe();
        ticks(w + 1, 0);
        check("R8 rearmed by character", idle_pending, 1'b1);
    endtask

    task automatic t_gaps();
        int w;
        w = window(0, 0, 0);
        disable_once();
        set_fmt(0, 0, 0);
        strobe();
        ticks(w, 2);
        cycles(1000);
        check("R9 idle clocks do not count", idle_pending, 1'b0);
        ticks(1, 2);
        check("R9 fires on tick count", idle_pending, 1'b1);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        idle_en = 1'b1;
        @(negedge clk);
        t_window(3, 0, 0, 0);
        t_window(0, 0, 0, 0);
        t_window(3, 1, 1, 0);
        t_window(1, 1, 0, 1);
        t_restart();
        t_unarmed();
        t_stall();
        t_sticky();
        t_clear_rearm();
        t_gaps();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule